// File: doc/BRIEF.md
# Subcycle-Sequenced Single-Register Processor Core

This block is a small 16-bit stored-program processor built around one general register, G. It holds a 12-bit program counter, a memory address register, a memory buffer register and an instruction register. It drives a 4096-word by 16-bit memory that sits outside the block. That memory is written on a clock edge. Its read port is combinational from the address the core presents.

Sequencing comes from outside through one-hot subcycle strobes. On each clock edge at most one strobe is high, and that strobe picks the step the core performs. The steps are:
- fetch the word at the program counter;
- increment the program counter;
- move the fetched word into the instruction register;
- place the operand address;
- access memory for the operand.

The top four instruction bits form the opcode. They are decoded into sixteen one-hot lines. The low twelve bits are a memory operand address, carried on the internal 16-bit bus with four zero bits above it.

An external run flag gates all activity. The core raises a halt request when it decodes the halt opcode. From then on it freezes until reset.

Top module: `sp16_core`

## Requirements
- R1: While rst_n is low and right after it is released, pc_o, mar_o, mbr_o, ir_o and g_o read 0, halt_o reads 0 and mem_we_o reads 0.
- R2: On an edge where strobe 0 is high and the core is active, mar_o takes pc_o and mbr_o takes the memory word at pc_o. The core is active when run_i is 1 and halt_o is 0. While strobe 0 is high, mem_addr_o equals pc_o.
- R3: pc_o changes only on an active edge with strobe 1 high. On that edge it becomes pc_o + 1 modulo 4096, so 0xFFF wraps to 0x000.
- R4: ir_o changes only on an active edge with strobe 2 high. On that edge it takes the value of mbr_o.
- R5: On an active edge with strobe 3 high, if the opcode ir_o[15:12] is 1 (add), 6 (load G) or 7 (store G), mar_o takes ir_o[11:0]. While any strobe other than 0 is high, mem_addr_o equals mar_o.
- R6: Opcode 6 (load G): on an active edge with strobe 4 high, g_o takes the memory word at mar_o.
- R7: Opcode 7 (store G): mem_we_o is 1 exactly while strobe 4 is high and the core is active, with mem_addr_o = mar_o and mem_wdata_o = g_o. In every other case mem_we_o is 0.
- R8: Opcode 1 (add): on an active edge with strobe 4 high, g_o becomes g_o plus the memory word at mar_o, modulo 2^16. For example, 0xABCD + 0x1234 = 0xBE01.
- R9: Opcode 0 (halt): on an active edge with strobe 3 high, halt_o rises. It stays high until reset. While halt_o is high, no register changes and mem_we_o stays 0.
- R10: While run_i is 0, no register changes and mem_we_o stays 0.
- R11: The opcodes 2 to 5 and 8 to 15, including the word 0xFFFF, change neither mar_o nor g_o in strobes 3 and 4, and cause no memory write.
- R12: A program of the following steps leaves 0xBE01 at address 0x202:
  - load G from 0x100 (holding 0xABCD);
  - store G to 0x200;
  - load G from 0x101 (holding 0x1234);
  - store G to 0x201;
  - add 0x200;
  - store G to 0x202;
  - halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | 5 | One-hot subcycle strobes; bit k selects step k |
| run_i | input | 1 | External run flag; 0 freezes the core |
| mem_rdata_i | input | 16 | Memory read data for mem_addr_o |
| mem_addr_o | output | 12 | Memory address: pc_o in step 0, mar_o otherwise |
| mem_wdata_o | output | 16 | Write data (contents of G) |
| mem_we_o | output | 1 | Memory write enable for the store opcode |
| halt_o | output | 1 | Halt request, sticky until reset |
| pc_o | output | 12 | Program counter |
| mar_o | output | 12 | Memory address register |
| mbr_o | output | 16 | Memory buffer register |
| ir_o | output | 16 | Instruction register |
| g_o | output | 16 | General register G |

## Verification
Each register result is due on the single clock edge at which its strobe is high. The bench therefore checks register outputs 2 ns after that edge, before it drives the next strobe.

The memory address, write enable and write data are combinational from the strobe and the current registers. They are checked 1 ns after the strobe is driven, in the same cycle.

A reference model in the bench advances once per edge. It uses the pre-edge register values and memory contents, so an expected write lands in the bench memory only after the edge that consumes it.

// File: rtl/sp16_pkg.sv
package sp16_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 12;
    localparam int OP_W    = 4;
    localparam int NUM_SC  = 5;
    localparam int NUM_OPS = 1 << OP_W;

    // subcycle strobe indices; the order is the execution sequence
    localparam int SC_FETCH = 0;
    localparam int SC_INCR  = 1;
    localparam int SC_XFER  = 2;
    localparam int SC_ADDR  = 3;
    localparam int SC_EXEC  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_HALT  = 4'h0,
        OP_ADD   = 4'h1,
        OP_LOADG = 4'h6,
        OP_STORG = 4'h7,
        OP_NOP   = 4'hF
    } opcode_e;

    // decoder lines that perform no work
    localparam logic [NUM_OPS-1:0] IDLE_MASK =
        ~((NUM_OPS'(1) << OP_HALT) | (NUM_OPS'(1) << OP_ADD) |
          (NUM_OPS'(1) << OP_LOADG) | (NUM_OPS'(1) << OP_STORG));

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] g;
        logic              halt;
    } core_state_t;

endpackage

// File: rtl/sp16_decoder.sv
module sp16_decoder #(
    parameter int IN_W = 4,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  code_i,
    output logic [OUT_N-1:0] line_o
);
    for (genvar li = 0; li < OUT_N; li++) begin : g_line
        assign line_o[li] = (code_i == IN_W'(li));
    end
endmodule

// File: rtl/sp16_incr.sv
module sp16_incr #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] a_i,
    output logic [WIDTH-1:0] sum_o
);
    // half-adder chain with a forced carry-in; the final carry is not built
    logic [WIDTH-1:0] carry;
    assign carry[0] = 1'b1;
    for (genvar bi = 0; bi < WIDTH; bi++) begin : g_ha
        assign sum_o[bi] = a_i[bi] ^ carry[bi];
        if (bi < WIDTH - 1) begin : g_c
            assign carry[bi+1] = a_i[bi] & carry[bi];
        end
    end
endmodule

// File: rtl/sp16_adder.sv
module sp16_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o
);
    // ripple full adders; the carry out of the top bit is dropped
    logic [WIDTH-1:0] carry;
    assign carry[0] = 1'b0;
    for (genvar bi = 0; bi < WIDTH; bi++) begin : g_fa
        assign sum_o[bi] = a_i[bi] ^ b_i[bi] ^ carry[bi];
        if (bi < WIDTH - 1) begin : g_c
            assign carry[bi+1] = (a_i[bi] & b_i[bi]) | (carry[bi] & (a_i[bi] ^ b_i[bi]));
        end
    end
endmodule

// File: rtl/sp16_core.sv
module sp16_core
    import sp16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SC-1:0] phase_i,
    input  logic              run_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              halt_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] mar_o,
    output logic [DATA_W-1:0] mbr_o,
    output logic [DATA_W-1:0] ir_o,
    output logic [DATA_W-1:0] g_o
);
    core_state_t state_q, state_d;

    logic [NUM_OPS-1:0] op_line;
    logic [ADDR_W-1:0]  pc_inc;
    logic [DATA_W-1:0]  g_sum;
    logic [DATA_W-1:0]  bus;
    logic               active;
    logic               op_idle;
    logic               op_mem;

    sp16_decoder #(.IN_W(OP_W)) u_dec (
        .code_i (state_q.ir[DATA_W-1 -: OP_W]),
        .line_o (op_line)
    );

    sp16_incr #(.WIDTH(ADDR_W)) u_inc (
        .a_i   (state_q.pc),
        .sum_o (pc_inc)
    );

    sp16_adder #(.WIDTH(DATA_W)) u_add (
        .a_i   (state_q.g),
        .b_i   (mem_rdata_i),
        .sum_o (g_sum)
    );

    always_comb begin
        active  = run_i & ~state_q.halt;
        op_idle = |(op_line & IDLE_MASK);
        op_mem  = ~op_idle & ~op_line[OP_HALT];

        // internal bus: one source per subcycle, operands zero-extended
        bus = '0;
        if (phase_i[SC_FETCH])     bus = DATA_W'(state_q.pc);
        else if (phase_i[SC_XFER]) bus = state_q.mbr;
        else if (phase_i[SC_ADDR]) bus = DATA_W'(state_q.ir[ADDR_W-1:0]);

        state_d = state_q;
        if (active) begin
            if (phase_i[SC_FETCH]) begin
                state_d.mar = bus[ADDR_W-1:0];
                state_d.mbr = mem_rdata_i;
            end
            if (phase_i[SC_INCR]) state_d.pc = pc_inc;
            if (phase_i[SC_XFER]) state_d.ir = bus;
            if (phase_i[SC_ADDR]) begin
                if (op_mem)            state_d.mar  = bus[ADDR_W-1:0];
                if (op_line[OP_HALT])  state_d.halt = 1'b1;
            end
            if (phase_i[SC_EXEC]) begin
                if (op_line[OP_LOADG]) state_d.g = mem_rdata_i;
                if (op_line[OP_ADD])   state_d.g = g_sum;
            end
        end

        mem_addr_o  = phase_i[SC_FETCH] ? state_q.pc : state_q.mar;
        mem_wdata_o = state_q.g;
        mem_we_o    = active & phase_i[SC_EXEC] & op_line[OP_STORG];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign halt_o = state_q.halt;
    assign pc_o   = state_q.pc;
    assign mar_o  = state_q.mar;
    assign mbr_o  = state_q.mbr;
    assign ir_o   = state_q.ir;
    assign g_o    = state_q.g;
endmodule

// File: rtl/sp16_core_chk.sv
module sp16_core_chk
    import sp16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_SC-1:0] phase_i,
    input logic              run_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_we_o,
    input logic              halt_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] mar_o,
    input logic [DATA_W-1:0] ir_o,
    input logic [DATA_W-1:0] g_o
);
    AST_PC_ONLY_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_o) |-> $past(phase_i[SC_INCR] && run_i)); // R3

    AST_PC_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_i[SC_INCR] && run_i && !halt_o))
        |-> pc_o == ADDR_W'($past(pc_o) + 1'b1)); // R3

    AST_IR_ONLY_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ir_o) |-> $past(phase_i[SC_XFER])); // R4

    AST_G_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(g_o) |-> $past(phase_i[SC_EXEC])); // R6

    AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (phase_i[SC_EXEC] && run_i && !halt_o && ir_o[DATA_W-1 -: OP_W] == OP_STORG)); // R7

    AST_WE_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o == mar_o && mem_wdata_o == g_o)); // R7

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(halt_o)) |-> halt_o); // R9

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!run_i || halt_o))
        |-> ($stable(pc_o) && $stable(g_o) && $stable(mar_o) && $stable(ir_o))); // R10

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        phase_i[SC_FETCH] |-> mem_addr_o == pc_o); // R2
endmodule

bind sp16_core sp16_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_i     (phase_i),
    .run_i       (run_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .halt_o      (halt_o),
    .pc_o        (pc_o),
    .mar_o       (mar_o),
    .ir_o        (ir_o),
    .g_o         (g_o)
);

// File: tb/tb_sp16_core.sv
`timescale 1ns/1ps
module tb_sp16_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  phase;
    logic        run;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic        halt;
    logic [11:0] pc, mar;
    logic [15:0] mbr, ir, g;

    logic [15:0] mem [4096];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // expected state
    logic [11:0] e_pc, e_mar;
    logic [15:0] e_mbr, e_ir, e_g;
    logic        e_halt;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    sp16_core dut (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .run_i(run),
        .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_we_o(mem_we), .halt_o(halt), .pc_o(pc), .mar_o(mar),
        .mbr_o(mbr), .ir_o(ir), .g_o(g)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        check(tag, "pc",   16'(pc),   16'(e_pc));
        check(tag, "mar",  16'(mar),  16'(e_mar));
        check(tag, "mbr",  mbr,       e_mbr);
        check(tag, "ir",   ir,        e_ir);
        check(tag, "g",    g,         e_g);
        check(tag, "halt", 16'(halt), 16'(e_halt));
    endtask

    function automatic string tag_of(input int p, input logic act, input logic [3:0] op);
        if (!act) return "R10";
        case (p)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return (op == 4'h0) ? "R9" : (op == 4'h1 || op == 4'h6 || op == 4'h7) ? "R5" : "R11";
            default: return (op == 4'h6) ? "R6" : (op == 4'h1) ? "R8" :
                            (op == 4'h7) ? "R7" : (op == 4'h0) ? "R9" : "R11";
        endcase
    endfunction

    // one strobe, one edge; entered and left just after a falling edge
    task automatic step(input int p, input logic r);
        logic act;
        logic [3:0] op;
        logic [11:0] ea;
        logic ewe;
        logic [15:0] rd;
        string tag;
        logic [11:0] n_pc, n_mar;
        logic [15:0] n_mbr, n_ir, n_g;
        logic n_halt;
        phase = 5'(1 << p);
        run = r;
        #1;
        act = r && !e_halt;
        op = e_ir[15:12];
        tag = tag_of(p, act, op);
        ea = (p == 0) ? e_pc : e_mar;
        ewe = act && p == 4 && op == 4'h7;
        check((p == 0) ? "R2" : "R5", "mem_addr", 16'(mem_addr), 16'(ea));
        check(ewe ? "R7" : tag, "mem_we", 16'(mem_we), 16'(ewe));
        if (ewe) check("R7", "mem_wdata", mem_wdata, e_g);
        rd = mem[ea];
        n_pc = e_pc; n_mar = e_mar; n_mbr = e_mbr; n_ir = e_ir; n_g = e_g; n_halt = e_halt;
        if (act) begin
            case (p)
                0: begin n_mar = e_pc; n_mbr = rd; end
                1: n_pc = e_pc + 12'd1;
                2: n_ir = e_mbr;
                3: begin
                    if (op == 4'h1 || op == 4'h6 || op == 4'h7) n_mar = e_ir[11:0];
                    if (op == 4'h0) n_halt = 1'b1;
                end
                default: begin
                    if (op == 4'h6) n_g = rd;
                    if (op == 4'h1) n_g = e_g + rd;
                end
            endcase
        end
        @(posedge clk);
        #2;
        if (ewe) mem[e_mar] = e_g;
        e_pc = n_pc; e_mar = n_mar; e_mbr = n_mbr; e_ir = n_ir; e_g = n_g; e_halt = n_halt;
        check_regs(tag);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; phase = '0; run = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        e_pc = '0; e_mar = '0; e_mbr = '0; e_ir = '0; e_g = '0; e_halt = 1'b0;
        check_regs("R1");
        check("R1", "mem_we", 16'(mem_we), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_instr(input bit gaps);
        for (int p = 0; p < 5; p++) begin
            if (gaps && ($urandom % 8) == 0) step(p, 1'b0);
            step(p, 1'b1);
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        @(negedge clk);
        do_reset();

        // R12: directed program, starting with an all-ones no-op word (R11)
        mem[0] = 16'hFFFF; mem[1] = 16'h6100; mem[2] = 16'h7200;
        mem[3] = 16'h6101; mem[4] = 16'h7201; mem[5] = 16'h1200;
        mem[6] = 16'h7202; mem[7] = 16'h0000;
        mem[12'h100] = 16'hABCD; mem[12'h101] = 16'h1234;
        for (int n = 0; n < 12 && !e_halt; n++) run_instr(1'b0);
        check("R12", "mem[200]", mem[12'h200], 16'hABCD);
        check("R12", "mem[201]", mem[12'h201], 16'h1234);
        check("R12", "mem[202]", mem[12'h202], 16'hBE01);
        check("R8", "g sum", g, 16'hBE01);
        check("R9", "halted", 16'(halt), 16'd1);
        // R9: frozen after halt even with run high
        for (int p = 0; p < 5; p++) step(p, 1'b1);

        // R3: wrap of the program counter across 4096 no-ops
        do_reset();
        for (int i = 0; i < 4096; i++) mem[i] = 16'hFFFF;
        for (int n = 0; n < 4096; n++) run_instr(1'b0);
        check("R3", "pc wrap", 16'(pc), 16'd0);

        // random programs with run gaps (R10) and mixed opcodes
        for (int round = 0; round < 6; round++) begin
            do_reset();
            for (int i = 0; i < 4096; i++) mem[i] = 16'($urandom);
            for (int n = 0; n < 60 && !e_halt; n++) begin
                logic [3:0] op;
                int sel;
                sel = int'($urandom % 16);
                op = (sel < 3) ? 4'h1 : (sel < 7) ? 4'h6 : (sel < 10) ? 4'h7 :
                     (sel == 10 && n > 40) ? 4'h0 : 4'($urandom);
                if (op == 4'h0 && n <= 40) op = 4'hF;
                mem[e_pc] = {op, 12'($urandom)};
                run_instr(1'b1);
            end
            for (int p = 0; p < 5; p++) step(p, 1'b0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule